// File: doc/BRIEF.md
# Endian-Mode Load/Store Address Munger

This block sits between a core's load/store pipe and a 64-bit-wide, byte-addressed data memory whose lanes are arranged big-endian. A per-request mode bit lets the memory appear little-endian to software. The data is never byte-reversed. In little-endian mode the block inverts the low three address bits with a pattern that depends on the operand size. It then places the operand in the addressed lanes in big-endian order. A value stored in one mode therefore reads back correctly in that same mode. The physical image in memory differs between the two modes.

Each request carries an address, a size code, write data, a write flag and the mode bit. The block drives the memory enable, write enable, doubleword address, per-lane byte enables and lane-aligned write data in the same cycle. The memory returns its read word one cycle later. The block then produces a right-justified, zero-extended result flagged by a valid pulse. A request whose address is not a multiple of its size raises a fault one cycle later. Such a request never reaches memory and produces no data.

Top module: `ls_endian_front`

## Requirements
- R1: With `req_le` low, the starting lane equals `req_addr[2:0]`, so a 1-byte access at address a enables only lane a.
- R2: With `req_le` high, a 4-byte access inverts address bit 2 only. A word at offset 0 occupies lanes 4..7 and a word at offset 4 occupies lanes 0..3.
- R3: With `req_le` high, a 2-byte access inverts address bits 2 and 1. A halfword load from offset 0 reads lanes 6 and 7.
- R4: With `req_le` high, a 1-byte access inverts address bits 2, 1 and 0, pairing offsets 0/7, 1/6, 2/5 and 3/4.
- R5: With `req_le` high, an 8-byte access is not inverted and enables all eight lanes.
- R6: `mem_be` bit i enables lane i, and lane i is `mem_wdata`/`mem_rdata` bits [63-8i:56-8i]. Lane 0 is the most significant byte. An accepted access enables exactly 2^`req_size` contiguous lanes from the starting lane. `mem_be` is zero when `mem_en` is low.
- R7: Write data is taken from the low 2^`req_size` bytes of `req_wdata`. Its most significant byte goes to the starting lane. Lanes outside the access are left unchanged in memory.
- R8: A legal read raises `rd_valid` in the next cycle. `rd_data` then holds the operand right-justified, with bits above the operand zero. `rd_valid` is low in every other cycle.
- R9: If `req_addr` is not a multiple of 2^`req_size`, `mem_en` and `mem_we` stay low. In the next cycle `align_fault` is high, `rd_valid` is low and `rd_data` is zero.
- R10: `mem_addr` is `req_addr` with its low three bits removed (the doubleword index). Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes.
- R11: After reset `rd_valid` and `align_fault` are low and `mem_en` is low while no request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_le | input | 1 | Little-endian view enable |
| req_size | input | 2 | Size code, bytes = 2^code |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Store operand, right-justified |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W-3 | Doubleword index |
| mem_be | output | 8 | Lane enables, bit i = lane i |
| mem_wdata | output | 64 | Lane-placed store data |
| mem_rdata | input | 64 | Memory read word, one cycle after request |
| rd_valid | output | 1 | Load result valid |
| align_fault | output | 1 | Misaligned request flagged |
| rd_data | output | 64 | Right-justified load result |

## Verification
A wrong inversion pattern or lane start shows up in `mem_be` during the request cycle itself. A store through such a path corrupts neighbouring bytes, and that corruption surfaces on the next load of those bytes through the other endian view. A stale or corrupted registered lane start or size makes `rd_data` wrong in the cycle after the load, with either the wrong bytes or nonzero upper bits. A fault flag stuck or lost shows on `align_fault` or `rd_valid` exactly one cycle after the offending request.

// File: rtl/ls_endian_pkg.sv
package ls_endian_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } acc_size_e;
endpackage

// File: rtl/ls_addr_munge.sv
// Size-dependent inversion of the in-word address bits plus the
// natural-alignment test.
module ls_addr_munge #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LANES  = 8
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [1:0]                 size,
  input  logic                       le_mode,
  output logic [$clog2(LANES)-1:0]   lane_start,
  output logic                       misaligned
);
  localparam int unsigned LB = $clog2(LANES);

  logic [LB:0]   span_m1;
  logic [LB-1:0] low_mask;
  logic [LB-1:0] flip;

  always_comb begin
    span_m1  = ({{LB{1'b0}}, 1'b1} << size) - 1'b1;
    low_mask = span_m1[LB-1:0];
    // Inverting only the bits above the operand keeps it inside the
    // same naturally aligned group of lanes.
    flip       = le_mode ? ~low_mask : '0;
    lane_start = addr[LB-1:0] ^ flip;
    misaligned = |(addr[LB-1:0] & low_mask);
  end
endmodule

// File: rtl/ls_write_steer.sv
// Byte enables and big-endian placement of the store operand.
module ls_write_steer #(
  parameter int unsigned LANES = 8
) (
  input  logic                       enable,
  input  logic [$clog2(LANES)-1:0]   lane_start,
  input  logic [1:0]                 size,
  input  logic [8*LANES-1:0]         op_data,
  output logic [LANES-1:0]           byte_en,
  output logic [8*LANES-1:0]         lane_data
);
  localparam int unsigned LB = $clog2(LANES);
  localparam int unsigned DW = 8 * LANES;

  logic [LB:0] span;
  logic [LB:0] last;

  always_comb begin
    span = {{LB{1'b0}}, 1'b1} << size;
    last = {1'b0, lane_start} + span - 1'b1;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LB:0] op_idx;
    logic        hit;
    assign hit    = enable && ((LB+1)'(i) >= {1'b0, lane_start}) && ((LB+1)'(i) <= last);
    assign op_idx = last - (LB+1)'(i);
    assign byte_en[i] = hit;
    assign lane_data[DW-1-8*i -: 8] = hit ? op_data[8*op_idx[LB-1:0] +: 8] : 8'h00;
  end
endmodule

// File: rtl/ls_read_align.sv
// Holds the lane placement of a load for one cycle and right-justifies
// the memory word when it returns.
module ls_read_align #(
  parameter int unsigned LANES = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_req,
  input  logic                       fault_req,
  input  logic [$clog2(LANES)-1:0]   lane_start,
  input  logic [1:0]                 size,
  input  logic [8*LANES-1:0]         mem_rdata,
  output logic                       rd_valid,
  output logic                       align_fault,
  output logic [8*LANES-1:0]         rd_data
);
  localparam int unsigned LB = $clog2(LANES);
  localparam int unsigned DW = 8 * LANES;

  logic [LB-1:0] start_q;
  logic [1:0]    size_q;
  logic [LB:0]   span_q;
  logic [LB:0]   last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid    <= 1'b0;
      align_fault <= 1'b0;
      start_q     <= '0;
      size_q      <= '0;
    end else begin
      rd_valid    <= rd_req;
      align_fault <= fault_req;
      if (rd_req) begin
        start_q <= lane_start;
        size_q  <= size;
      end
    end
  end

  always_comb begin
    span_q = {{LB{1'b0}}, 1'b1} << size_q;
    last_q = {1'b0, start_q} + span_q - 1'b1;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_byte
    logic [LB:0] src_lane;
    logic        used;
    assign used     = (LB+1)'(k) < span_q;
    assign src_lane = last_q - (LB+1)'(k);
    assign rd_data[8*k +: 8] = (rd_valid && used)
                               ? mem_rdata[DW-1-8*src_lane[LB-1:0] -: 8] : 8'h00;
  end
endmodule

// File: rtl/ls_endian_front.sv
module ls_endian_front #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LANES  = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              req_valid,
  input  logic                              req_write,
  input  logic                              req_le,
  input  logic [1:0]                        req_size,
  input  logic [ADDR_W-1:0]                 req_addr,
  input  logic [8*LANES-1:0]                req_wdata,
  output logic                              mem_en,
  output logic                              mem_we,
  output logic [ADDR_W-$clog2(LANES)-1:0]   mem_addr,
  output logic [LANES-1:0]                  mem_be,
  output logic [8*LANES-1:0]                mem_wdata,
  input  logic [8*LANES-1:0]                mem_rdata,
  output logic                              rd_valid,
  output logic                              align_fault,
  output logic [8*LANES-1:0]                rd_data
);
  import ls_endian_pkg::*;

  localparam int unsigned LB = $clog2(LANES);

  logic [LB-1:0] lane_start;
  logic          misaligned;
  logic          accept;

  ls_addr_munge #(.ADDR_W(ADDR_W), .LANES(LANES)) u_munge (
    .addr       (req_addr),
    .size       (req_size),
    .le_mode    (req_le),
    .lane_start (lane_start),
    .misaligned (misaligned)
  );

  assign accept   = req_valid && !misaligned;
  assign mem_en   = accept;
  assign mem_we   = accept && req_write;
  assign mem_addr = req_addr[ADDR_W-1:LB];

  ls_write_steer #(.LANES(LANES)) u_steer (
    .enable     (accept),
    .lane_start (lane_start),
    .size       (req_size),
    .op_data    (req_wdata),
    .byte_en    (mem_be),
    .lane_data  (mem_wdata)
  );

  ls_read_align #(.LANES(LANES)) u_read (
    .clk         (clk),
    .rst         (rst),
    .rd_req      (accept && !req_write),
    .fault_req   (req_valid && misaligned),
    .lane_start  (lane_start),
    .size        (req_size),
    .mem_rdata   (mem_rdata),
    .rd_valid    (rd_valid),
    .align_fault (align_fault),
    .rd_data     (rd_data)
  );
endmodule

// File: rtl/ls_endian_front_chk.sv
module ls_endian_front_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LANES  = 8
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              req_valid,
  input logic                              req_write,
  input logic                              req_le,
  input logic [1:0]                        req_size,
  input logic [ADDR_W-1:0]                 req_addr,
  input logic                              mem_en,
  input logic                              mem_we,
  input logic [ADDR_W-$clog2(LANES)-1:0]   mem_addr,
  input logic [LANES-1:0]                  mem_be,
  input logic                              rd_valid,
  input logic                              align_fault,
  input logic [8*LANES-1:0]                rd_data
);
  localparam int unsigned LB = $clog2(LANES);

  logic [LB:0]      sz_m1;
  logic             bad;
  logic [LANES-1:0] one_lane;
  logic [LANES-1:0] four_lanes;

  always_comb begin
    sz_m1      = ({{LB{1'b0}}, 1'b1} << req_size) - 1'b1;
    bad        = |(req_addr[LB-1:0] & sz_m1[LB-1:0]);
    one_lane   = {{(LANES-1){1'b0}}, 1'b1};
    four_lanes = {{(LANES-4){1'b0}}, 4'hF};
  end

  // R9
  misaligned_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && bad) |-> (!mem_en && !mem_we));

  // R9
  misaligned_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && bad) |=> (align_fault && !rd_valid && rd_data == '0));

  // R8
  load_valid_next_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && !bad) |=> (rd_valid && !align_fault));

  // R8
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write && !bad) |=> !rd_valid);

  // R6
  lane_count_chk: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> ($countones(mem_be) == (1 << req_size)));

  // R6
  idle_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_en |-> (mem_be == '0));

  // R10
  dword_index_chk: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> (mem_addr == req_addr[ADDR_W-1:LB]));

  // R1
  be_byte_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !req_le && req_size == 2'd0) |-> (mem_be == (one_lane << req_addr[LB-1:0])));

  // R4
  le_byte_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_en && req_le && req_size == 2'd0)
      |-> (mem_be == (one_lane << (req_addr[LB-1:0] ^ {LB{1'b1}}))));

  // R2
  le_word_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_en && req_le && req_size == 2'd2)
      |-> (mem_be == (four_lanes << (req_addr[LB-1:0] ^ ~LB'(3)))));

  // R5
  le_dword_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_en && req_le && req_size == 2'd3) |-> (mem_be == '1));

  // R11
  exclusive_result_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && align_fault));
endmodule

bind ls_endian_front ls_endian_front_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_le      (req_le),
  .req_size    (req_size),
  .req_addr    (req_addr),
  .mem_en      (mem_en),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_be      (mem_be),
  .rd_valid    (rd_valid),
  .align_fault (align_fault),
  .rd_data     (rd_data)
);

// File: tb/ls_endian_front_test.sv
module ls_endian_front_test;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic              req_le = 1'b0;
  logic [1:0]        req_size = 2'd0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [63:0]       req_wdata = '0;
  logic              mem_en, mem_we;
  logic [ADDR_W-4:0] mem_addr;
  logic [7:0]        mem_be;
  logic [63:0]       mem_wdata;
  logic [63:0]       mem_rdata = '0;
  logic              rd_valid, align_fault;
  logic [63:0]       rd_data;

  ls_endian_front #(.ADDR_W(ADDR_W), .LANES(8)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_le(req_le), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rd_valid(rd_valid), .align_fault(align_fault),
    .rd_data(rd_data)
  );

  always #10 clk = ~clk;

  typedef struct {
    bit          is_fault;
    logic [63:0] data;
    int          due;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          cyc = 0;
  int          total = 0;
  int          fails = 0;
  logic [7:0]  phys [0:63];
  logic [63:0] bmem [0:7];

  always @(posedge clk) cyc <= cyc + 1;

  // Memory model: lane i is bits [63-8i -: 8], one-cycle read latency.
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int i = 0; i < 8; i++)
          if (mem_be[i]) bmem[mem_addr[2:0]][63-8*i -: 8] <= mem_wdata[63-8*i -: 8];
      end else begin
        mem_rdata <= bmem[mem_addr[2:0]];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int flip_of(input bit le, input int sz);
    if (!le) return 0;
    case (sz)
      0: return 7;
      1: return 6;
      2: return 4;
      default: return 0;
    endcase
  endfunction

  // Monitor: compares results due this cycle against the scoreboard.
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      if (e.is_fault) begin
        chk(align_fault && !rd_valid, e.tag, "fault flags", {62'd0, align_fault, rd_valid}, 64'd2);
        chk(rd_data == 64'd0, e.tag, "fault data zero", rd_data, 64'd0);
      end else begin
        chk(rd_valid && !align_fault, e.tag, "read valid", {62'd0, align_fault, rd_valid}, 64'd1);
        chk(rd_data == e.data, e.tag, "read data", rd_data, e.data);
      end
    end else if (!rst && (rd_valid || align_fault)) begin
      chk(1'b0, "R8", "unexpected result", {62'd0, align_fault, rd_valid}, 64'd0);
    end
  end

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  // Driver: presents one request, checks the memory-side pins and
  // pushes the expected result.
  task automatic req(input bit w, input bit le, input int sz, input int addr,
                     input logic [63:0] wd, input string tag);
    int          n, s, base;
    bit          mis;
    logic [7:0]  ebe;
    logic [63:0] ed;
    exp_t        e;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = w;
    req_le    = le;
    req_size  = 2'(sz);
    req_addr  = ADDR_W'(addr);
    req_wdata = wd;
    #1;
    n    = 1 << sz;
    mis  = (addr % n) != 0;
    s    = (addr % 8) ^ flip_of(le, sz);
    base = addr - (addr % 8);
    ebe  = 8'h00;
    if (!mis) for (int j = 0; j < n; j++) ebe[s+j] = 1'b1;
    chk(mem_en == !mis, mis ? "R9" : "R6", {tag, " mem_en"}, {63'd0, mem_en}, {63'd0, !mis});
    chk(mem_we == (w && !mis), mis ? "R9" : "R7", {tag, " mem_we"}, {63'd0, mem_we}, {63'd0, w && !mis});
    chk(mem_be == ebe, "R6", {tag, " mem_be"}, {56'd0, mem_be}, {56'd0, ebe});
    if (!mis) chk(mem_addr == ADDR_W'(addr) >> 3, "R10", {tag, " mem_addr"},
                  {51'd0, mem_addr}, 64'(addr >> 3));
    if (mis) begin
      e.is_fault = 1'b1; e.data = '0; e.due = cyc + 1; e.tag = {"R9 ", tag};
      sb.push_back(e);
    end else if (w) begin
      for (int j = 0; j < n; j++) phys[base + s + j] = wd[8*(n-1-j) +: 8];
    end else begin
      ed = '0;
      for (int j = 0; j < n; j++) ed = (ed << 8) | 64'(phys[base + s + j]);
      e.is_fault = 1'b0; e.data = ed; e.due = cyc + 1; e.tag = tag;
      sb.push_back(e);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int p = 0; p < 64; p++) phys[p] = 8'(p * 7 + 3);
    for (int d = 0; d < 8; d++)
      for (int i = 0; i < 8; i++) bmem[d][63-8*i -: 8] = phys[8*d + i];

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: quiet during and after reset
    chk(!rd_valid && !align_fault, "R11", "reset flags", {62'd0, rd_valid, align_fault}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(!mem_en && !rd_valid && !align_fault, "R11", "idle after reset",
        {61'd0, mem_en, rd_valid, align_fault}, 64'd0);

    // R2: little-endian word store to 0 lands in lanes 4..7
    req(1, 1, 2, 0, 64'h0000_0000_0102_0304, "R2 le word store");
    // R7: big-endian doubleword view shows bytes 0..3 untouched
    req(0, 0, 3, 0, '0, "R7 be dword view");
    // R4: byte load at 0 reads physical byte 7 (0x04)
    req(0, 1, 0, 0, '0, "R4 le byte ld 0");
    // R3: halfword load at 0 reads lanes 6,7 (0x0304)
    req(0, 1, 1, 0, '0, "R3 le half ld 0");
    // R2: word at offset 4 maps to lanes 0..3
    req(0, 1, 2, 4, '0, "R2 le word ld 4");
    // R5: doubleword in LE mode is not inverted
    req(0, 1, 3, 8, '0, "R5 le dword ld");
    // R1: big-endian byte loads pass the offset through
    req(0, 0, 0, 5, '0, "R1 be byte ld 5");
    req(0, 0, 1, 2, '0, "R1 be half ld 2");
    idle();

    // R4: LE byte store at 17 hits physical 22; BE load of 22 sees it
    req(1, 1, 0, 17, 64'hFFFF_FFFF_FFFF_FF5A, "R4 le byte st 17");
    req(0, 0, 0, 22, '0, "R4 be byte ld 22");
    req(0, 0, 3, 16, '0, "R7 neighbours intact");

    // Round trips for every mode, size and aligned offset
    for (int le = 0; le < 2; le++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 8; off += (1 << sz)) begin
          req(1, le[0], sz, 24 + off, 64'hC3B2_A190_8776_6554 ^ 64'(off * 37 + sz * 11 + le),
              le ? "R7 le store" : "R7 be store");
          req(0, le[0], sz, 24 + off, '0, le ? "R8 le load back" : "R8 be load back");
        end
    req(0, 0, 3, 24, '0, "R8 be dword after sweep");
    req(0, 1, 1, 30, '0, "R3 le half ld 30");
    idle();

    // R9: misaligned store and load never reach memory
    req(1, 1, 2, 34, 64'hDEAD_BEEF, "R9 word st 34");
    req(0, 0, 1, 35, '0, "R9 half ld 35");
    req(1, 0, 3, 44, 64'h1111_2222_3333_4444, "R9 dword st 44");
    req(0, 0, 3, 32, '0, "R9 dword 32 unchanged");
    req(0, 0, 3, 40, '0, "R9 dword 40 unchanged");
    idle();
    idle();
    idle();
    chk(sb.size() == 0, "R8", "scoreboard drained", 64'(sb.size()), 64'd0);
    finish_run();
  end
endmodule